// File: doc/BRIEF.md
# In-Order Pipeline Hazard Scoreboard

This block is the control skeleton of a four-stage in-order pipeline with fetch, decode, issue and execute stages. Each instruction enters with a tag, two optional source registers and one optional destination register. A register is named by a register-file code and an index. The block carries only the tag and the register references down the pipeline. It performs no arithmetic and decodes no opcodes.

A pending-write bit per architectural register tracks results that have not been written yet. Decode compares its sources against these bits, and also its destination, which keeps a second writer from overtaking an unfinished one. If any of them is pending, decode holds itself and fetch, and sends an empty slot into issue. When decode lets an instruction through, its destination becomes pending. Execute keeps a short queue of slots. An issued instruction reaches the write-back slot after a fixed latency. There it retires its destination through a single write port, if the port is offered that cycle, and clears the pending bit.

A write-back that cannot get the port freezes every stage. Sources that decode finds free while it waits are recorded as read and are not checked again. Upstream logic must hold its instruction while `stall` is high. The instruction is taken on the first rising edge at which `stall` is low.

Top module: `hsb_pipe_ctrl`

## Requirements
- R1: During and right after reset, every stage valid (`fe_vld`, `de_vld`, `is_vld`, `wb_vld`) is 0, `stall` is 0 and `ret_vld` is 0.
- R2: A hazard-free instruction accepted at edge k is in the write-back slot after edge k+5. It retires in that cycle when `wr_avail` is 1, with `ret_vld`=1 and its tag, file and index. A stream of independent instructions retires one per cycle without raising `stall`.
- R3: Decode raises `stall` while any valid source in either source slot names a register with a pending write. A consumer sent on the edge right after its producer sees 4 stall cycles and retires 5 cycles after the producer. With one independent instruction between them, it sees 3 stall cycles.
- R4: Decode also raises `stall` while its own destination is pending. Two back-to-back writers of the same register behave like R3: 4 stall cycles and a 5-cycle retire gap.
- R5: File code 0 selects 32 general registers and code 1 selects 32 floating registers. Code 2 selects 8 condition fields, using the index modulo 8. Equal indices in different files do not conflict. File code 3 names no register: it never stalls and never retires.
- R6: While the write-back slot holds an unwritten destination and `wr_avail` is 0, `stall` is 1, `ret_vld` is 0 and every stage tag and valid stays frozen. The write retires in the first cycle that `wr_avail` returns to 1.
- R7: A decode hazard holds only fetch and decode. Issue receives an empty slot, and execute keeps draining, so the producer retires while its consumer waits.
- R8: Input is taken only on a rising edge with `stall` low. Instructions retire in the order they were accepted. An instruction offered during a stall is accepted on the edge after the stall ends.
- R9: Empty stages raise no stall and reserve nothing. An idle pipeline keeps `stall` at 0, and cycles with `in_vld`=0 produce no retire events.
- R10: An instruction accepted at edge k shows its tag on `fe_tag` after edge k, on `de_tag` after edge k+1, on `is_tag` after edge k+2 and on `wb_tag` after edge k+5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Offered instruction is real |
| in_tag | input | TAG_W | Instruction tag |
| in_s0_vld | input | 1 | Source 0 present |
| in_s0_file | input | 2 | Source 0 file code |
| in_s0_idx | input | 5 | Source 0 index |
| in_s1_vld | input | 1 | Source 1 present |
| in_s1_file | input | 2 | Source 1 file code |
| in_s1_idx | input | 5 | Source 1 index |
| in_d_vld | input | 1 | Destination present |
| in_d_file | input | 2 | Destination file code |
| in_d_idx | input | 5 | Destination index |
| wr_avail | input | 1 | Register write port free this cycle |
| stall | output | 1 | Pipeline held; input not taken |
| fe_vld | output | 1 | Fetch stage occupied |
| fe_tag | output | TAG_W | Fetch stage tag |
| de_vld | output | 1 | Decode stage occupied |
| de_tag | output | TAG_W | Decode stage tag |
| is_vld | output | 1 | Issue stage occupied |
| is_tag | output | TAG_W | Issue stage tag |
| wb_vld | output | 1 | Write-back slot occupied |
| wb_tag | output | TAG_W | Write-back slot tag |
| ret_vld | output | 1 | A destination retires this cycle |
| ret_tag | output | TAG_W | Tag of the retiring instruction |
| ret_file | output | 2 | File code of the retired register |
| ret_idx | output | 5 | Index of the retired register |

## Verification
Two functions can fall in one cycle: a retire clearing a pending bit, and a decode hazard waiting on that same bit. A consumer is sent on the edge right after its producer, so the producer's write-back lands while decode is still held. The test then checks the exact stall count and that the consumer retires five cycles after the producer, one cycle after the clear becomes visible. A second collision, a write-back freeze landing while later instructions sit behind it, comes from withdrawing `wr_avail`. The test checks that every stage stays frozen and that the held write retires on the first cycle the port returns.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  localparam int IDX_W = 5;
  localparam int NGPR  = 32;
  localparam int NFPR  = 32;
  localparam int NCR   = 8;
  localparam int NREG  = NGPR + NFPR + NCR;
  localparam int SB_W  = $clog2(NREG);

  typedef enum logic [1:0] {
    RF_GPR  = 2'd0,
    RF_FPR  = 2'd1,
    RF_CR   = 2'd2,
    RF_NONE = 2'd3
  } rfile_e;

  typedef struct packed {
    logic             vld;
    rfile_e           file;
    logic [IDX_W-1:0] idx;
  } reg_ref_t;

  typedef struct packed {
    logic            ok;
    logic [SB_W-1:0] slot;
  } sb_ref_t;

  // Flatten (file, index) onto one pending-bit position.
  function automatic sb_ref_t map_reg(input reg_ref_t r);
    sb_ref_t m;
    m.ok   = 1'b0;
    m.slot = '0;
    if (r.vld) begin
      case (r.file)
        RF_GPR: begin m.ok = 1'b1; m.slot = SB_W'(int'(r.idx) % NGPR); end
        RF_FPR: begin m.ok = 1'b1; m.slot = SB_W'(NGPR + (int'(r.idx) % NFPR)); end
        RF_CR:  begin m.ok = 1'b1; m.slot = SB_W'(NGPR + NFPR + (int'(r.idx) % NCR)); end
        default: ;
      endcase
    end
    return m;
  endfunction
endpackage

// File: rtl/hsb_scoreboard.sv
module hsb_scoreboard import hsb_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [SB_W-1:0] set_slot,
  input  logic            clr_en,
  input  logic [SB_W-1:0] clr_slot,
  output logic [NREG-1:0] pend
);
  logic [NREG-1:0] pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (clr_en) pend_d[clr_slot] = 1'b0;
    if (set_en) pend_d[set_slot] = 1'b1;   // a reservation outranks a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;

  // R4: a new reservation survives a same-cycle clear of that register
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && clr_en && (set_slot == clr_slot)) |=> pend_q[$past(set_slot)]);
endmodule

// File: rtl/hsb_wb_queue.sv
module hsb_wb_queue import hsb_pkg::*; #(
  parameter int TAG_W  = 8,
  parameter int WB_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             wr_avail,
  input  logic             in_vld,
  input  logic [TAG_W-1:0] in_tag,
  input  reg_ref_t         in_dst,
  input  logic [SB_W-1:0]  in_slot,
  input  logic             in_need,
  output logic             wb_vld,
  output logic [TAG_W-1:0] wb_tag,
  output logic             ret_vld,
  output reg_ref_t         ret_dst,
  output logic [SB_W-1:0]  ret_slot,
  output logic             wb_stall
);
  localparam int DEPTH = WB_LAT + 1;

  logic             q_vld  [DEPTH];
  logic [TAG_W-1:0] q_tag  [DEPTH];
  reg_ref_t         q_dst  [DEPTH];
  logic [SB_W-1:0]  q_slot [DEPTH];
  logic             q_need [DEPTH];

  logic             s_vld  [DEPTH];
  logic [TAG_W-1:0] s_tag  [DEPTH];
  reg_ref_t         s_dst  [DEPTH];
  logic [SB_W-1:0]  s_slot [DEPTH];
  logic             s_need [DEPTH];

  // Slot k is fed from slot k+1; the farthest slot takes the issued entry.
  for (genvar k = 0; k < DEPTH; k++) begin : g_src
    if (k == DEPTH - 1) begin : g_top
      assign s_vld[k]  = in_vld;
      assign s_tag[k]  = in_tag;
      assign s_dst[k]  = in_dst;
      assign s_slot[k] = in_slot;
      assign s_need[k] = in_need;
    end else begin : g_mid
      assign s_vld[k]  = q_vld[k+1];
      assign s_tag[k]  = q_tag[k+1];
      assign s_dst[k]  = q_dst[k+1];
      assign s_slot[k] = q_slot[k+1];
      assign s_need[k] = q_need[k+1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) begin
        q_vld[k]  <= 1'b0;
        q_tag[k]  <= '0;
        q_dst[k]  <= '0;
        q_slot[k] <= '0;
        q_need[k] <= 1'b0;
      end
    end else if (adv) begin
      for (int k = 0; k < DEPTH; k++) begin
        q_vld[k]  <= s_vld[k];
        q_tag[k]  <= s_tag[k];
        q_dst[k]  <= s_dst[k];
        q_slot[k] <= s_slot[k];
        q_need[k] <= s_need[k];
      end
    end
  end

  assign wb_vld   = q_vld[0];
  assign wb_tag   = q_tag[0];
  assign ret_vld  = q_vld[0] & q_need[0] & wr_avail;
  assign wb_stall = q_vld[0] & q_need[0] & ~wr_avail;
  assign ret_dst  = q_dst[0];
  assign ret_slot = q_slot[0];

  // R6: a write waiting for the port keeps its slot unchanged
  a_r6_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stall |=> (q_vld[0] && $stable(q_tag[0])));

  // R2: an entry one step from write-back arrives there on an advance
  a_r2_slot_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && q_vld[1]) |=> (q_vld[0] && (q_tag[0] == $past(q_tag[1]))));
endmodule

// File: rtl/hsb_pipe_ctrl.sv
module hsb_pipe_ctrl import hsb_pkg::*; #(
  parameter int TAG_W  = 8,
  parameter int WB_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             in_s0_vld,
  input  logic [1:0]       in_s0_file,
  input  logic [IDX_W-1:0] in_s0_idx,
  input  logic             in_s1_vld,
  input  logic [1:0]       in_s1_file,
  input  logic [IDX_W-1:0] in_s1_idx,
  input  logic             in_d_vld,
  input  logic [1:0]       in_d_file,
  input  logic [IDX_W-1:0] in_d_idx,
  input  logic             wr_avail,
  output logic             stall,
  output logic             fe_vld,
  output logic [TAG_W-1:0] fe_tag,
  output logic             de_vld,
  output logic [TAG_W-1:0] de_tag,
  output logic             is_vld,
  output logic [TAG_W-1:0] is_tag,
  output logic             wb_vld,
  output logic [TAG_W-1:0] wb_tag,
  output logic             ret_vld,
  output logic [TAG_W-1:0] ret_tag,
  output logic [1:0]       ret_file,
  output logic [IDX_W-1:0] ret_idx
);
  reg_ref_t in_s0, in_s1, in_ds;
  assign in_s0 = '{vld: in_s0_vld, file: rfile_e'(in_s0_file), idx: in_s0_idx};
  assign in_s1 = '{vld: in_s1_vld, file: rfile_e'(in_s1_file), idx: in_s1_idx};
  assign in_ds = '{vld: in_d_vld,  file: rfile_e'(in_d_file),  idx: in_d_idx};

  // fetch, decode and issue registers
  logic             f_vld_q, f_vld_d, d_vld_q, d_vld_d, i_vld_q, i_vld_d;
  logic [TAG_W-1:0] f_tag_q, f_tag_d, d_tag_q, d_tag_d, i_tag_q, i_tag_d;
  reg_ref_t         f_s0_q, f_s0_d, f_s1_q, f_s1_d, f_ds_q, f_ds_d;
  reg_ref_t         d_s0_q, d_s0_d, d_s1_q, d_s1_d, d_ds_q, d_ds_d;
  reg_ref_t         i_ds_q, i_ds_d;
  logic [SB_W-1:0]  i_slot_q, i_slot_d;
  logic             i_need_q, i_need_d;

  logic [NREG-1:0]  pend;
  sb_ref_t          m0, m1, md;
  logic             haz0, haz1, hazw, dec_stall, wb_stall;
  logic             front_adv, back_adv, set_en;
  logic             q_ret;
  reg_ref_t         q_ret_dst;
  logic [SB_W-1:0]  q_ret_slot;

  assign m0 = map_reg(d_s0_q);
  assign m1 = map_reg(d_s1_q);
  assign md = map_reg(d_ds_q);

  assign haz0      = d_vld_q & m0.ok & pend[m0.slot];
  assign haz1      = d_vld_q & m1.ok & pend[m1.slot];
  assign hazw      = d_vld_q & md.ok & pend[md.slot];
  assign dec_stall = haz0 | haz1 | hazw;

  assign stall     = wb_stall | dec_stall;
  assign back_adv  = ~wb_stall;
  assign front_adv = ~stall;
  assign set_en    = front_adv & d_vld_q & md.ok;

  always_comb begin
    f_vld_d = f_vld_q;  f_tag_d = f_tag_q;
    f_s0_d  = f_s0_q;   f_s1_d  = f_s1_q;  f_ds_d = f_ds_q;
    d_vld_d = d_vld_q;  d_tag_d = d_tag_q;
    d_s0_d  = d_s0_q;   d_s1_d  = d_s1_q;  d_ds_d = d_ds_q;
    i_vld_d = i_vld_q;  i_tag_d = i_tag_q;
    i_ds_d  = i_ds_q;   i_slot_d = i_slot_q; i_need_d = i_need_q;
    if (front_adv) begin
      f_vld_d = in_vld;   f_tag_d = in_tag;
      f_s0_d  = in_s0;    f_s1_d  = in_s1;   f_ds_d = in_ds;
      d_vld_d = f_vld_q;  d_tag_d = f_tag_q;
      d_s0_d  = f_s0_q;   d_s1_d  = f_s1_q;  d_ds_d = f_ds_q;
    end else begin
      // sources found free while waiting count as read
      d_s0_d.vld = d_s0_q.vld & (haz0 | ~d_vld_q);
      d_s1_d.vld = d_s1_q.vld & (haz1 | ~d_vld_q);
    end
    if (back_adv) begin
      if (front_adv) begin
        i_vld_d  = d_vld_q;  i_tag_d = d_tag_q;
        i_ds_d   = d_ds_q;   i_slot_d = md.slot;
        i_need_d = d_vld_q & md.ok;
      end else begin
        i_vld_d  = 1'b0;     // decode hazard: bubble into issue
        i_need_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_vld_q <= 1'b0; f_tag_q <= '0; f_s0_q <= '0; f_s1_q <= '0; f_ds_q <= '0;
      d_vld_q <= 1'b0; d_tag_q <= '0; d_s0_q <= '0; d_s1_q <= '0; d_ds_q <= '0;
      i_vld_q <= 1'b0; i_tag_q <= '0; i_ds_q <= '0; i_slot_q <= '0; i_need_q <= 1'b0;
    end else begin
      f_vld_q <= f_vld_d; f_tag_q <= f_tag_d; f_s0_q <= f_s0_d; f_s1_q <= f_s1_d; f_ds_q <= f_ds_d;
      d_vld_q <= d_vld_d; d_tag_q <= d_tag_d; d_s0_q <= d_s0_d; d_s1_q <= d_s1_d; d_ds_q <= d_ds_d;
      i_vld_q <= i_vld_d; i_tag_q <= i_tag_d; i_ds_q <= i_ds_d; i_slot_q <= i_slot_d;
      i_need_q <= i_need_d;
    end
  end

  hsb_scoreboard u_sb (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (set_en),
    .set_slot (md.slot),
    .clr_en   (q_ret),
    .clr_slot (q_ret_slot),
    .pend     (pend)
  );

  hsb_wb_queue #(.TAG_W(TAG_W), .WB_LAT(WB_LAT)) u_exq (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (back_adv),
    .wr_avail (wr_avail),
    .in_vld   (i_vld_q),
    .in_tag   (i_tag_q),
    .in_dst   (i_ds_q),
    .in_slot  (i_slot_q),
    .in_need  (i_need_q),
    .wb_vld   (wb_vld),
    .wb_tag   (wb_tag),
    .ret_vld  (q_ret),
    .ret_dst  (q_ret_dst),
    .ret_slot (q_ret_slot),
    .wb_stall (wb_stall)
  );

  assign fe_vld   = f_vld_q;
  assign fe_tag   = f_tag_q;
  assign de_vld   = d_vld_q;
  assign de_tag   = d_tag_q;
  assign is_vld   = i_vld_q;
  assign is_tag   = i_tag_q;
  assign ret_vld  = q_ret;
  assign ret_tag  = wb_tag;
  assign ret_file = q_ret_dst.file;
  assign ret_idx  = q_ret_dst.idx;

  // R7: a decode-only hazard sends an empty slot into issue
  a_r7_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_stall && !wb_stall) |=> !i_vld_q);

  // R8: fetch and decode hold their instructions across a stall
  a_r8_front_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(f_vld_q) && $stable(f_tag_q) && $stable(d_vld_q) && $stable(d_tag_q)));
endmodule

// File: tb/hsb_pipe_ctrl_tb_top.sv
`timescale 1ns/1ps
module hsb_pipe_ctrl_tb_top;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_vld = 1'b0;
  logic [TW-1:0] in_tag = '0;
  logic          in_s0_vld = 1'b0, in_s1_vld = 1'b0, in_d_vld = 1'b0;
  logic [1:0]    in_s0_file = '0, in_s1_file = '0, in_d_file = '0;
  logic [4:0]    in_s0_idx = '0, in_s1_idx = '0, in_d_idx = '0;
  logic          wr_avail = 1'b1;
  logic          stall, fe_vld, de_vld, is_vld, wb_vld, ret_vld;
  logic [TW-1:0] fe_tag, de_tag, is_tag, wb_tag, ret_tag;
  logic [1:0]    ret_file;
  logic [4:0]    ret_idx;

  always #2 clk = ~clk;   // 250 MHz

  hsb_pipe_ctrl #(.TAG_W(TW), .WB_LAT(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_tag(in_tag),
    .in_s0_vld(in_s0_vld), .in_s0_file(in_s0_file), .in_s0_idx(in_s0_idx),
    .in_s1_vld(in_s1_vld), .in_s1_file(in_s1_file), .in_s1_idx(in_s1_idx),
    .in_d_vld(in_d_vld), .in_d_file(in_d_file), .in_d_idx(in_d_idx),
    .wr_avail(wr_avail), .stall(stall),
    .fe_vld(fe_vld), .fe_tag(fe_tag), .de_vld(de_vld), .de_tag(de_tag),
    .is_vld(is_vld), .is_tag(is_tag), .wb_vld(wb_vld), .wb_tag(wb_tag),
    .ret_vld(ret_vld), .ret_tag(ret_tag), .ret_file(ret_file), .ret_idx(ret_idx)
  );

  typedef struct { int tag; int file; int idx; } exp_t;
  exp_t exp_q[$];
  int   n_chk = 0, n_bad = 0, cyc = 0, stall_cnt = 0;
  int   acc_cyc [256];
  int   ret_cyc [256];
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: compare each retire against the expected queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall) stall_cnt++;
      if (ret_vld) begin
        ret_cyc[ret_tag] = cyc;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected retire tag", int'(ret_tag), -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(int'(ret_tag) == e.tag, "R8", "retire tag order", int'(ret_tag), e.tag);
          chk(int'(ret_file) == e.file && int'(ret_idx) == e.idx, "R2", "retire register",
              int'({ret_file, ret_idx}), (e.file << 5) | e.idx);
        end
      end
    end
  end

  task automatic send(input int tag,
                      input bit s0v, input int s0f, input int s0i,
                      input bit s1v, input int s1f, input int s1i,
                      input bit dv,  input int df,  input int di);
    @(negedge clk);
    while (stall) @(negedge clk);
    in_vld = 1'b1; in_tag = TW'(tag);
    in_s0_vld = s0v; in_s0_file = 2'(s0f); in_s0_idx = 5'(s0i);
    in_s1_vld = s1v; in_s1_file = 2'(s1f); in_s1_idx = 5'(s1i);
    in_d_vld  = dv;  in_d_file  = 2'(df);  in_d_idx  = 5'(di);
    if (dv && df != 3) begin
      exp_t e;
      e.tag = tag; e.file = df; e.idx = di;
      exp_q.push_back(e);
    end
    @(posedge clk);
    #1;
    acc_cyc[tag] = cyc;
    in_vld = 1'b0; in_s0_vld = 1'b0; in_s1_vld = 1'b0; in_d_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin acc_cyc[i] = -1; ret_cyc[i] = -1; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!stall && !fe_vld && !de_vld && !is_vld && !wb_vld && !ret_vld, "R1", "reset outputs",
        int'({stall, fe_vld, de_vld, is_vld, wb_vld, ret_vld}), 0);
    rst_n = 1'b1;
    idle(2);
    chk(!stall && !fe_vld && !wb_vld, "R1", "outputs after release",
        int'({stall, fe_vld, wb_vld}), 0);
    idle(3);
    chk(!stall, "R9", "idle pipeline stall", int'(stall), 0);

    // R2 independent stream
    stall_cnt = 0;
    for (int t = 1; t <= 4; t++) send(t, 1, 0, 20, 0, 0, 0, 1, 0, t);
    idle(12);
    chk(ret_cyc[1] - acc_cyc[1] == 5, "R2", "accept-to-retire latency", ret_cyc[1] - acc_cyc[1], 5);
    for (int t = 1; t < 4; t++)
      chk(ret_cyc[t+1] - ret_cyc[t] == 1, "R2", "one retire per cycle", ret_cyc[t+1] - ret_cyc[t], 1);
    chk(stall_cnt == 0, "R2", "stall cycles on independent stream", stall_cnt, 0);

    // R10 stage tags
    send(5, 0, 0, 0, 0, 0, 0, 1, 0, 30);
    @(negedge clk);
    chk(fe_vld && fe_tag == 5, "R10", "fetch tag", int'(fe_tag), 5);
    @(negedge clk);
    chk(de_vld && de_tag == 5, "R10", "decode tag", int'(de_tag), 5);
    @(negedge clk);
    chk(is_vld && is_tag == 5, "R10", "issue tag", int'(is_tag), 5);
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk(wb_vld && wb_tag == 5, "R10", "write-back tag", int'(wb_tag), 5);
    idle(6);

    // R3 / R7 back-to-back dependence through source 0
    stall_cnt = 0;
    send(10, 0, 0, 0, 0, 0, 0, 1, 0, 5);
    send(11, 1, 0, 5, 0, 0, 0, 1, 0, 6);
    idle(16);
    chk(ret_cyc[11] - ret_cyc[10] == 5, "R3", "consumer retire gap", ret_cyc[11] - ret_cyc[10], 5);
    chk(stall_cnt == 4, "R3", "stall cycles back-to-back", stall_cnt, 4);
    chk(ret_cyc[10] - acc_cyc[10] == 5, "R7", "producer drains during hazard", ret_cyc[10] - acc_cyc[10], 5);

    // R3 dependence through source 1 with one instruction between
    stall_cnt = 0;
    send(12, 0, 0, 0, 0, 0, 0, 1, 0, 7);
    send(13, 0, 0, 0, 0, 0, 0, 1, 0, 8);
    send(14, 1, 0, 9, 1, 0, 7, 1, 0, 16);
    idle(16);
    chk(stall_cnt == 3, "R3", "stall cycles with gap", stall_cnt, 3);
    chk(ret_cyc[14] - ret_cyc[12] == 5, "R3", "source-1 consumer gap", ret_cyc[14] - ret_cyc[12], 5);
    chk(ret_cyc[13] - ret_cyc[12] == 1, "R7", "independent passes ahead", ret_cyc[13] - ret_cyc[12], 1);

    // R4 two writers of one register
    stall_cnt = 0;
    send(15, 0, 0, 0, 0, 0, 0, 1, 0, 10);
    send(16, 0, 0, 0, 0, 0, 0, 1, 0, 10);
    idle(16);
    chk(stall_cnt == 4, "R4", "stall cycles on repeated destination", stall_cnt, 4);
    chk(ret_cyc[16] - ret_cyc[15] == 5, "R4", "second writer gap", ret_cyc[16] - ret_cyc[15], 5);

    // R5 file separation, condition aliasing, no-register code
    stall_cnt = 0;
    send(17, 0, 0, 0, 0, 0, 0, 1, 0, 3);
    send(18, 1, 1, 3, 0, 0, 0, 1, 1, 4);
    idle(12);
    chk(stall_cnt == 0, "R5", "general vs floating same index", stall_cnt, 0);
    chk(ret_cyc[18] - ret_cyc[17] == 1, "R5", "files independent gap", ret_cyc[18] - ret_cyc[17], 1);
    stall_cnt = 0;
    send(20, 0, 0, 0, 0, 0, 0, 1, 2, 2);
    send(21, 1, 2, 10, 0, 0, 0, 1, 0, 11);
    idle(16);
    chk(stall_cnt == 4, "R5", "condition index modulo 8", stall_cnt, 4);
    stall_cnt = 0;
    send(22, 0, 0, 0, 0, 0, 0, 1, 3, 0);
    send(23, 1, 3, 0, 0, 0, 0, 1, 0, 12);
    idle(12);
    chk(stall_cnt == 0, "R5", "file code 3 stalls", stall_cnt, 0);
    chk(ret_cyc[22] == -1, "R5", "file code 3 retire cycle", ret_cyc[22], -1);

    // R6 write port withheld
    @(posedge clk); #1 wr_avail = 1'b0;
    send(30, 0, 0, 0, 0, 0, 0, 1, 0, 13);
    send(31, 0, 0, 0, 0, 0, 0, 1, 0, 14);
    @(negedge clk);
    while (!wb_vld) @(negedge clk);
    chk(stall && !ret_vld && wb_tag == 30, "R6", "frozen write-back",
        int'({stall, ret_vld, wb_tag}), int'({1'b1, 1'b0, 8'd30}));
    begin
      logic [3:0] snap;
      snap = {fe_vld, de_vld, is_vld, wb_vld};
      for (int n = 0; n < 3; n++) begin
        @(negedge clk);
        chk(stall && !ret_vld && wb_tag == 30 && {fe_vld, de_vld, is_vld, wb_vld} == snap,
            "R6", "stages stay frozen", int'({stall, ret_vld, fe_vld, de_vld, is_vld, wb_vld}),
            int'({1'b1, 1'b0, snap}));
      end
    end
    @(posedge clk); #1 wr_avail = 1'b1;
    @(negedge clk);
    chk(ret_vld && ret_tag == 30, "R6", "retire when port returns", int'(ret_tag), 30);
    idle(8);
    chk(ret_cyc[31] - ret_cyc[30] == 1, "R6", "follower after release", ret_cyc[31] - ret_cyc[30], 1);

    // R8 input held during a stall, order preserved
    send(40, 0, 0, 0, 0, 0, 0, 1, 0, 17);
    send(41, 1, 0, 17, 0, 0, 0, 1, 0, 18);
    send(42, 0, 0, 0, 0, 0, 0, 1, 0, 19);
    send(43, 1, 0, 18, 0, 0, 0, 1, 0, 21);
    idle(24);
    chk(acc_cyc[43] - acc_cyc[42] == 5, "R8", "held input accepted after stall",
        acc_cyc[43] - acc_cyc[42], 5);
    chk(exp_q.size() == 0, "R8", "expected retires outstanding", exp_q.size(), 0);
    chk(!stall && !wb_vld, "R9", "drained pipeline quiet", int'({stall, wb_vld}), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule